// File: doc/BRIEF.md
# SPI Packet Master Engine

This block is the serial core of an SPI master. It drives the clock, one active-low chip select and the outgoing data line, and it captures the incoming data line. The block pulls transmit bytes one at a time through a valid/ready handshake and hands back each received byte as a one-cycle strobe. A transfer is a number of equal-sized packets sent back to back, so the byte count is the packet size times the repeat count. Both sizes are programmed as minus-one values.

Every timing field is a minus-one count of controller clocks:
- the clock's high time and low time;
- the select setup time before the first clock edge;
- the hold time after the last edge;
- the deselected gap that must pass before the engine reports completion.

Clock polarity and phase choose among the four usual SPI modes. Each direction has its own bit-order select.

A hold-select option ends a transfer in a paused state with the chip select still low, so a later resume pulse can send another programmed run inside the same frame. A soft reset aborts from any state.

Top module: `spi_pkt_engine`

## Requirements
- R1: After reset the engine is idle: cs_n_o=1, sck_o equals cpol_i, and busy_o, paused_o, done_o and pause_irq_o are all 0.
- R2: One transfer moves exactly (pkt_len_i+1)*(pkt_loops_i+1) bytes. Each byte is taken through one tx_valid_i/tx_ready_o handshake, and each produces one rx_valid_o strobe.
- R3: With tx_msb_i=1 each byte goes out bit 7 first; with tx_msb_i=0 it goes out bit 0 first.
- R4: With rx_msb_i=1 the first bit received lands in bit 7 of rx_data_o; with rx_msb_i=0 it lands in bit 0.
- R5: SCK rests at the level of cpol_i. With cpha_i=0 data is presented before the leading edge and captured on it. With cpha_i=1 data is presented on the leading edge and captured on the trailing edge. Each byte makes exactly 16 SCK transitions.
- R6: Within a byte, the non-rest level of SCK lasts (cpol_i ? sck_lo_i : sck_hi_i)+1 clocks, and the rest level between two bits lasts (cpol_i ? sck_hi_i : sck_lo_i)+1 clocks.
- R7: The first SCK edge comes cs_setup_i+3+(rest-level field) clocks after cs_n_o falls, provided a transmit byte is already offered. The 3 is one setup clock, one fetch clock and one clock for the rest phase.
- R8: Without pause, cs_n_o rises cs_hold_i+1 clocks after the last SCK edge. The done indication follows cs_idle_i+1 clocks after that, at the same moment busy_o falls.
- R9: start_i has an effect only when idle, and resume_i has an effect only when paused.
- R10: With pause_en_i=1, the end of the programmed bytes leaves cs_n_o low, sets paused_o and pulses pause_irq_o when pause_ie_i=1. resume_i then runs a further full programmed transfer without a new select setup.
- R11: done_o is a single-cycle pulse, produced only when done_ie_i=1. busy_o falls either way.
- R12: If no transmit byte is offered, the engine waits with SCK at its rest level, CS held low and no SCK transitions until one arrives.
- R13: soft_rst_i returns the engine to idle one clock later from any state, with cs_n_o=1 and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (idle only) |
| resume_i | input | 1 | Continue from the paused state |
| soft_rst_i | input | 1 | Abort to idle |
| cpol_i | input | 1 | SCK rest level |
| cpha_i | input | 1 | Capture on trailing edge when 1 |
| tx_msb_i | input | 1 | Transmit bit order, 1 = MSB first |
| rx_msb_i | input | 1 | Receive bit order, 1 = MSB first |
| pause_en_i | input | 1 | Hold select at end of transfer |
| done_ie_i | input | 1 | Enable the done pulse |
| pause_ie_i | input | 1 | Enable the pause pulse |
| sck_hi_i | input | 8 | SCK high time minus one |
| sck_lo_i | input | 8 | SCK low time minus one |
| cs_setup_i | input | 8 | Select setup minus one |
| cs_hold_i | input | 8 | Select hold minus one |
| cs_idle_i | input | 8 | Deselected gap minus one |
| pkt_len_i | input | 10 | Bytes per packet minus one |
| pkt_loops_i | input | 8 | Packets per transfer minus one |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Engine takes the byte this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o strobe |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | Transfer finished pulse |
| pause_irq_o | output | 1 | Entered paused state pulse |
| paused_o | output | 1 | Engine is paused |
| busy_o | output | 1 | Engine not idle |

## Verification
Almost every fault in the phase counter or the sequencer changes an SCK interval. Such a fault shows up as a wrong high or low width, setup gap, hold gap or idle gap, and it appears within the first byte, a few clocks after it happens. A bit index or byte counter that is off by one changes the number of SCK transitions per byte or the number of handshakes per transfer. A wrong phase or bit-order choice corrupts the first byte seen by the bench's slave model. Faults in the pause path show up in the few clocks after the last byte, as CS rising, a missing or extra pulse, or a resume that re-runs the setup.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Sequencer states of the serial engine.
  typedef enum logic [2:0] {
    ST_IDLE,   // deselected, waiting for start
    ST_SETUP,  // select low, counting setup time
    ST_FETCH,  // waiting for a transmit byte
    ST_REST,   // SCK at rest level for one bit
    ST_ACT,    // SCK at active level for one bit
    ST_HOLD,   // select low after last edge
    ST_GAP,    // deselected minimum gap
    ST_PAUSE   // select held low, waiting for resume
  } eng_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [DW-1:0]          tx_byte_i,
  input  logic                   tx_msb_i,
  input  logic                   rx_msb_i,
  input  logic [$clog2(DW)-1:0]  sel_i,
  input  logic                   sample_i,
  input  logic                   miso_i,
  output logic                   tx_bit_o,
  output logic [DW-1:0]          rx_nxt_o
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] TOP = BW'(DW - 1);

  logic [DW-1:0] tx_q;
  logic [DW-1:0] rx_q;
  logic [DW-1:0] cur;

  // Bit select sees the byte being loaded in the same cycle.
  assign cur      = load_i ? tx_byte_i : tx_q;
  assign tx_bit_o = tx_msb_i ? cur[TOP - sel_i] : cur[sel_i];

  always_comb begin
    rx_nxt_o = rx_q;
    if (sample_i) begin
      if (rx_msb_i) rx_nxt_o = {rx_q[DW-2:0], miso_i};
      else          rx_nxt_o = {miso_i, rx_q[DW-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i) tx_q <= tx_byte_i;
      rx_q <= rx_nxt_o;
    end
  end

  // R3: a byte load never coincides with a capture strobe
  p_load_no_sample_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !sample_i);
endmodule

// File: rtl/spi_xfer_counter.sv
module spi_xfer_counter #(
  parameter int LW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [LW-1:0] len_i,
  input  logic [CW-1:0] loops_i,
  output logic          last_o
);
  logic [LW-1:0] byte_q;
  logic [CW-1:0] loop_q;

  assign last_o = (byte_q == len_i) && (loop_q == loops_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      byte_q <= '0;
      loop_q <= '0;
    end else if (step_i) begin
      if (last_o) begin
        byte_q <= '0;
        loop_q <= '0;
      end else if (byte_q == len_i) begin
        byte_q <= '0;
        loop_q <= loop_q + 1'b1;
      end else begin
        byte_q <= byte_q + 1'b1;
      end
    end
  end

  // R2: position within a packet never passes the programmed length
  p_byte_bound_r2: assert property (@(posedge clk) disable iff (rst)
    byte_q <= len_i);
  // R2: packet index never passes the programmed repeat count
  p_loop_bound_r2: assert property (@(posedge clk) disable iff (rst)
    loop_q <= loops_i);
endmodule

// File: rtl/spi_pkt_engine.sv
module spi_pkt_engine
  import spi_eng_pkg::*;
#(
  parameter int TW = 8,
  parameter int LW = 10,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          resume_i,
  input  logic          soft_rst_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          tx_msb_i,
  input  logic          rx_msb_i,
  input  logic          pause_en_i,
  input  logic          done_ie_i,
  input  logic          pause_ie_i,
  input  logic [TW-1:0] sck_hi_i,
  input  logic [TW-1:0] sck_lo_i,
  input  logic [TW-1:0] cs_setup_i,
  input  logic [TW-1:0] cs_hold_i,
  input  logic [TW-1:0] cs_idle_i,
  input  logic [LW-1:0] pkt_len_i,
  input  logic [CW-1:0] pkt_loops_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          cs_n_o,
  output logic          done_o,
  output logic          pause_irq_o,
  output logic          paused_o,
  output logic          busy_o
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  eng_state_e    state;
  logic [TW-1:0] cnt;
  logic [BW-1:0] bit_idx;

  logic [TW-1:0] len_rest, len_act;
  logic          cnt_zero, fetch_go, lead_edge, trail_edge, byte_end;
  logic          sample, last_byte, cnt_clr, tx_bit;
  logic [BW-1:0] sel_idx;
  logic [DW-1:0] rx_nxt;

  // Rest level is the idle level of SCK; its width comes from the
  // field that matches that level.
  assign len_rest = cpol_i ? sck_hi_i : sck_lo_i;
  assign len_act  = cpol_i ? sck_lo_i : sck_hi_i;

  assign cnt_zero   = (cnt == '0);
  assign fetch_go   = (state == ST_FETCH) && tx_valid_i;
  assign lead_edge  = (state == ST_REST) && cnt_zero;
  assign trail_edge = (state == ST_ACT) && cnt_zero;
  assign byte_end   = trail_edge && (bit_idx == LAST_BIT);
  assign sample     = cpha_i ? trail_edge : lead_edge;

  // Which bit to present next on MOSI.
  always_comb begin
    if (fetch_go)    sel_idx = '0;
    else if (cpha_i) sel_idx = bit_idx;
    else             sel_idx = bit_idx + 1'b1;
  end

  assign cnt_clr = soft_rst_i
                || ((state == ST_IDLE) && start_i)
                || ((state == ST_PAUSE) && resume_i);

  assign tx_ready_o = (state == ST_FETCH);
  assign paused_o   = (state == ST_PAUSE);
  assign busy_o     = (state != ST_IDLE);

  spi_byte_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (fetch_go),
    .tx_byte_i (tx_data_i),
    .tx_msb_i  (tx_msb_i),
    .rx_msb_i  (rx_msb_i),
    .sel_i     (sel_idx),
    .sample_i  (sample),
    .miso_i    (miso_i),
    .tx_bit_o  (tx_bit),
    .rx_nxt_o  (rx_nxt)
  );

  spi_xfer_counter #(.LW(LW), .CW(CW)) u_count (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (cnt_clr),
    .step_i  (byte_end),
    .len_i   (pkt_len_i),
    .loops_i (pkt_loops_i),
    .last_o  (last_byte)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst_i) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      bit_idx     <= '0;
      sck_o       <= cpol_i;
      mosi_o      <= 1'b0;
      cs_n_o      <= 1'b1;
      done_o      <= 1'b0;
      pause_irq_o <= 1'b0;
      rx_valid_o  <= 1'b0;
      if (rst) rx_data_o <= '0;
    end else begin
      done_o      <= 1'b0;
      pause_irq_o <= 1'b0;
      rx_valid_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sck_o <= cpol_i;
          if (start_i) begin
            state  <= ST_SETUP;
            cnt    <= cs_setup_i;
            cs_n_o <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) state <= ST_FETCH;
          else          cnt   <= cnt - 1'b1;
        end
        ST_FETCH: begin
          if (tx_valid_i) begin
            state   <= ST_REST;
            cnt     <= len_rest;
            bit_idx <= '0;
            if (!cpha_i) mosi_o <= tx_bit;
          end
        end
        ST_REST: begin
          if (cnt_zero) begin
            state <= ST_ACT;
            cnt   <= len_act;
            sck_o <= ~cpol_i;
            if (cpha_i) mosi_o <= tx_bit;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACT: begin
          if (cnt_zero) begin
            sck_o <= cpol_i;
            if (bit_idx == LAST_BIT) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= rx_nxt;
              if (!last_byte) begin
                state <= ST_FETCH;
              end else if (pause_en_i) begin
                state       <= ST_PAUSE;
                pause_irq_o <= pause_ie_i;
              end else begin
                state <= ST_HOLD;
                cnt   <= cs_hold_i;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              state   <= ST_REST;
              cnt     <= len_rest;
              if (!cpha_i) mosi_o <= tx_bit;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            cs_n_o <= 1'b1;
            state  <= ST_GAP;
            cnt    <= cs_idle_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            state  <= ST_IDLE;
            done_o <= done_ie_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PAUSE: begin
          if (resume_i) state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: idle always means deselected
  p_idle_cs_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> cs_n_o);
  // R10: the paused state keeps the select asserted
  p_pause_cs_r10: assert property (@(posedge clk) disable iff (rst)
    paused_o |-> !cs_n_o);
  // R11: completion is a one-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R12: while waiting for data SCK sits at its rest level
  p_stall_sck_r12: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |-> (sck_o == cpol_i));
  // R13: soft reset lands in idle, deselected, one clock later
  p_soft_rst_r13: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (cs_n_o && !busy_o && !done_o));
  // R11: done and pause never pulse together
  p_excl_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !(done_o && pause_irq_o));
endmodule

// File: tb/sim_spi_pkt_engine.sv
module sim_spi_pkt_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, resume_i = 0, soft_rst_i = 0;
  logic cpol_i = 0, cpha_i = 0, tx_msb_i = 1, rx_msb_i = 1;
  logic pause_en_i = 0, done_ie_i = 1, pause_ie_i = 1;
  logic [7:0] sck_hi_i = 0, sck_lo_i = 0, cs_setup_i = 0, cs_hold_i = 0, cs_idle_i = 0;
  logic [9:0] pkt_len_i = 0;
  logic [7:0] pkt_loops_i = 0;
  logic [7:0] tx_data_i = 0;
  logic tx_valid_i = 0;
  logic miso_i = 0;
  logic tx_ready_o, rx_valid_o, sck_o, mosi_o, cs_n_o, done_o, pause_irq_o, paused_o, busy_o;
  logic [7:0] rx_data_o;

  spi_pkt_engine u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .resume_i(resume_i), .soft_rst_i(soft_rst_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .tx_msb_i(tx_msb_i), .rx_msb_i(rx_msb_i),
    .pause_en_i(pause_en_i), .done_ie_i(done_ie_i), .pause_ie_i(pause_ie_i),
    .sck_hi_i(sck_hi_i), .sck_lo_i(sck_lo_i), .cs_setup_i(cs_setup_i),
    .cs_hold_i(cs_hold_i), .cs_idle_i(cs_idle_i), .pkt_len_i(pkt_len_i),
    .pkt_loops_i(pkt_loops_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
    .done_o(done_o), .pause_irq_o(pause_irq_o), .paused_o(paused_o), .busy_o(busy_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;

  // Monitor and slave-model state
  bit feed_en = 0;
  int tx_idx = 0;
  bit tx_take = 0;
  int n_edge = 0, n_tx = 0, n_rx = 0, n_done = 0, n_pirq = 0, n_csfall = 0;
  int cs_fall_t = 0, cs_rise_t = 0, done_t = 0;
  int edge_t [128];
  logic [7:0] got_tx [64];
  logic [7:0] got_rx [64];
  logic [7:0] s_sh = 0;
  int s_bit = 0, o_bit = 0, o_idx = 0;
  logic prev_cs = 1, prev_sck = 0;

  function automatic logic [7:0] tpat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] mpat(input int k);
    return 8'(((k * 91) + 90) & 255);
  endfunction
  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Transmit byte source
  initial forever begin
    @(negedge clk);
    if (tx_take) tx_idx++;
    tx_data_i  = tpat(tx_idx);
    tx_valid_i = feed_en;
    tx_take    = tx_ready_o && tx_valid_i;
  end

  // Port monitor plus SPI slave model (slave shifts MSB first)
  initial forever begin
    logic [7:0] tmp;
    @(negedge clk);
    if (cs_n_o && !prev_cs) cs_rise_t = cyc;
    if (!cs_n_o && prev_cs) begin
      n_csfall++;
      cs_fall_t = cyc;
      if (!cpha_i) begin
        o_bit = 0;
        tmp = mpat(o_idx);
        miso_i = tmp[7];
      end
    end
    if (sck_o != prev_sck) begin
      bit lead;
      lead = (sck_o != cpol_i);
      if (n_edge < 128) edge_t[n_edge] = cyc;
      n_edge++;
      if (lead != cpha_i) begin
        s_sh = {s_sh[6:0], mosi_o};
        s_bit++;
        if (s_bit == 8) begin
          if (n_tx < 64) got_tx[n_tx] = s_sh;
          n_tx++;
          s_bit = 0;
        end
      end else if (!cpha_i) begin
        o_bit++;
        if (o_bit == 8) begin o_bit = 0; o_idx++; end
        tmp = mpat(o_idx);
        miso_i = tmp[7-o_bit];
      end else begin
        tmp = mpat(o_idx);
        miso_i = tmp[7-o_bit];
        o_bit++;
        if (o_bit == 8) begin o_bit = 0; o_idx++; end
      end
    end
    if (rx_valid_o) begin
      if (n_rx < 64) got_rx[n_rx] = rx_data_o;
      n_rx++;
    end
    if (done_o) begin n_done++; done_t = cyc; end
    if (pause_irq_o) n_pirq++;
    prev_cs  = cs_n_o;
    prev_sck = sck_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_mon();
    n_edge = 0; n_tx = 0; n_rx = 0; n_done = 0; n_pirq = 0; n_csfall = 0;
    s_bit = 0; o_bit = 0; o_idx = 0; tx_idx = 0; tx_take = 0;
  endtask

  task automatic pulse_start();
    start_i = 1; tick(1); start_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000; i++) begin
      if (!busy_o) break;
      tick(1);
    end
    tick(1);
  endtask

  task automatic setup_cfg(input bit pl, input bit ph, input bit tm, input bit rm,
                           input int len, input int loops, input int hi, input int lo,
                           input int su, input int ho, input int id);
    cpol_i = pl; cpha_i = ph; tx_msb_i = tm; rx_msb_i = rm;
    pkt_len_i = 10'(len); pkt_loops_i = 8'(loops);
    sck_hi_i = 8'(hi); sck_lo_i = 8'(lo);
    cs_setup_i = 8'(su); cs_hold_i = 8'(ho); cs_idle_i = 8'(id);
    tick(3);
    clear_mon();
  endtask

  task automatic check_data(input string tag, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] et, er;
      et = tx_msb_i ? tpat(k) : rev8(tpat(k));
      er = rx_msb_i ? mpat(k) : rev8(mpat(k));
      chk_eq({tag, " R3 tx byte"}, int'(got_tx[k]), int'(et));
      chk_eq({tag, " R4 rx byte"}, int'(got_rx[k]), int'(er));
    end
  endtask

  // R1: state right after reset
  task automatic t_reset();
    chk_eq("R1 cs_n", int'(cs_n_o), 1);
    chk_eq("R1 sck", int'(sck_o), int'(cpol_i));
    chk_eq("R1 busy", int'(busy_o), 0);
    chk_eq("R1 paused", int'(paused_o), 0);
    chk_eq("R1 done", int'(done_o | pause_irq_o), 0);
  endtask

  // Full transfer in one mode with timing checks
  task automatic t_xfer(input string tag, input bit pl, input bit ph, input bit tm, input bit rm,
                        input int len, input int loops, input int hi, input int lo,
                        input int su, input int ho, input int id);
    int nb, ra, ac;
    setup_cfg(pl, ph, tm, rm, len, loops, hi, lo, su, ho, id);
    done_ie_i = 1; pause_en_i = 0;
    nb = (len + 1) * (loops + 1);
    ra = (pl ? hi : lo);
    ac = (pl ? lo : hi);
    feed_en = 1;
    pulse_start();
    wait_idle();
    chk_eq({tag, " R2 handshakes"}, tx_idx, nb);
    chk_eq({tag, " R2 rx strobes"}, n_rx, nb);
    chk_eq({tag, " R5 sck transitions"}, n_edge, 16 * nb);
    chk_eq({tag, " R5 rest level"}, int'(sck_o), int'(pl));
    check_data(tag, nb);
    chk_eq({tag, " R7 setup"}, edge_t[0] - cs_fall_t, su + 3 + ra);
    chk_eq({tag, " R6 active width"}, edge_t[1] - edge_t[0], ac + 1);
    chk_eq({tag, " R6 rest width"}, edge_t[2] - edge_t[1], ra + 1);
    chk_eq({tag, " R8 hold"}, cs_rise_t - edge_t[16 * nb - 1], ho + 1);
    chk_eq({tag, " R8 gap"}, done_t - cs_rise_t, id + 1);
    chk_eq({tag, " R11 done count"}, n_done, 1);
  endtask

  // R11: done suppressed when its enable is low
  task automatic t_nodone();
    setup_cfg(0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    done_ie_i = 0; feed_en = 1;
    pulse_start();
    wait_idle();
    chk_eq("R11 no done when disabled", n_done, 0);
    chk_eq("R11 busy falls", int'(busy_o), 0);
    chk_eq("R11 bytes", n_rx, 2);
    done_ie_i = 1;
  endtask

  // R12: waiting for a transmit byte
  task automatic t_stall();
    setup_cfg(1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 1);
    feed_en = 0;
    pulse_start();
    tick(30);
    chk_eq("R12 cs held", int'(cs_n_o), 0);
    chk_eq("R12 sck rest", int'(sck_o), 1);
    chk_eq("R12 no edges", n_edge, 0);
    chk_eq("R12 ready", int'(tx_ready_o), 1);
    feed_en = 1;
    wait_idle();
    chk_eq("R12 byte after stall", n_rx, 1);
    check_data("R12", 1);
  endtask

  // R9/R10: pause, ignored start, resume
  task automatic t_pause();
    int e0;
    setup_cfg(0, 1, 1, 0, 1, 0, 1, 0, 2, 1, 1);
    pause_en_i = 1; pause_ie_i = 1; feed_en = 1;
    pulse_start();
    for (int i = 0; i < 2000; i++) begin
      if (paused_o) break;
      tick(1);
    end
    tick(2);
    chk_eq("R10 paused flag", int'(paused_o), 1);
    chk_eq("R10 cs low", int'(cs_n_o), 0);
    chk_eq("R10 pause pulse", n_pirq, 1);
    chk_eq("R10 no done", n_done, 0);
    chk_eq("R10 bytes first run", n_rx, 2);
    e0 = n_edge;
    pulse_start();
    tick(10);
    chk_eq("R9 start ignored paused", int'(paused_o), 1);
    chk_eq("R9 no edges from start", n_edge, e0);
    pause_en_i = 0;
    resume_i = 1; tick(1); resume_i = 0;
    wait_idle();
    chk_eq("R10 total bytes", n_rx, 4);
    chk_eq("R10 single select", n_csfall, 1);
    chk_eq("R10 done after resume", n_done, 1);
    check_data("R10", 4);
  endtask

  // R9: resume in idle does nothing
  task automatic t_idle_resume();
    clear_mon();
    resume_i = 1; tick(1); resume_i = 0;
    tick(8);
    chk_eq("R9 resume ignored busy", int'(busy_o), 0);
    chk_eq("R9 resume ignored cs", int'(cs_n_o), 1);
    chk_eq("R9 resume ignored edges", n_edge, 0);
  endtask

  // R13 and R10 gating: soft reset out of a silent pause and mid-byte
  task automatic t_softrst();
    setup_cfg(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    pause_en_i = 1; pause_ie_i = 0; feed_en = 1;
    pulse_start();
    for (int i = 0; i < 2000; i++) begin
      if (paused_o) break;
      tick(1);
    end
    tick(1);
    chk_eq("R10 pause pulse gated", n_pirq, 0);
    chk_eq("R10 paused silent", int'(paused_o), 1);
    soft_rst_i = 1; tick(1); soft_rst_i = 0;
    chk_eq("R13 cs after reset", int'(cs_n_o), 1);
    chk_eq("R13 idle after reset", int'(busy_o), 0);
    pause_en_i = 0; pause_ie_i = 1;
    setup_cfg(0, 0, 1, 1, 3, 0, 3, 3, 0, 0, 0);
    pulse_start();
    tick(40);
    soft_rst_i = 1; tick(1); soft_rst_i = 0;
    chk_eq("R13 cs mid byte", int'(cs_n_o), 1);
    chk_eq("R13 sck rest", int'(sck_o), 0);
    tick(20);
    chk_eq("R13 no done", n_done, 0);
    setup_cfg(0, 0, 1, 1, 2, 0, 0, 0, 0, 0, 0);
    pulse_start();
    wait_idle();
    chk_eq("R13 clean restart bytes", n_rx, 3);
  endtask

  initial begin
    tick(4);
    rst = 0;
    tick(2);
    t_reset();
    t_xfer("m0", 0, 0, 1, 1, 2, 1, 1, 2, 1, 2, 3);
    t_xfer("m1", 0, 1, 0, 1, 0, 3, 0, 0, 0, 0, 0);
    t_xfer("m2", 1, 0, 1, 0, 1, 0, 3, 1, 2, 1, 0);
    t_xfer("m3", 1, 1, 0, 0, 0, 0, 2, 4, 5, 3, 2);
    t_nodone();
    t_stall();
    t_pause();
    t_idle_resume();
    t_softrst();
    summary();
  end
endmodule